// File: doc/BRIEF.md
# Serial Transceiver with Selectable Bit Clock

This block is an asynchronous serial transmitter and receiver for frames of one start bit, eight data bits sent least significant first, an optional ninth bit, and one stop bit. Its bit-rate tick is chosen at run time from three sources: the system clock divided by a fixed parameter, a single-cycle overflow pulse from an external timer, or an internal 16-bit divider loaded through two byte registers. Each bit lasts `OVS` ticks (16 by default).

Software drives the block through a byte-wide register port. A write to the data register queues a byte for sending, and a read of it returns the last accepted received byte. With the holding option on, the transmitter takes a second byte while the first is still shifting. In nine-bit operation the receiver can drop frames that are not meant for this node. It also flags frames with a bad stop bit and frames that stay low from start to stop. Two sticky flags serve as interrupt lines.

Top module: `usel_uart`

## Requirements
- R1: After reset `txd` is 1, both interrupt outputs are 0 and the status register (address 5) reads 0.
- R2: With source 0 (control bits [1:0] = 0) one tick occurs every `FIX_DIV` clocks. A bit therefore lasts `OVS*FIX_DIV` clocks. A frame is a 0 start bit, data LSB first, and a 1 stop bit.
- R3: With source 2 or 3, one tick occurs every D+1 clocks, where D = {register 3, register 2}. Register 3 is the upper byte.
- R4: With source 1, each cycle where `tim_ovf` is high is one tick. With no pulses, nothing is sent.
- R5: When control bit 2 (nine) is set, the frame carries a ninth bit between data and stop. That bit is the value of control bit 5 at the moment the data byte is written.
- R6: With control bit 4 set (holding), a second byte is accepted while the first is shifting. The two frames go out back to back, and each keeps its own ninth bit.
- R7: With control bit 4 clear, a data write made while a frame is in progress is ignored.
- R8: `tx_irq` (status bit 1) is set when the transmitter can take a byte again. With holding, this happens when a byte moves into the shifter. Without holding, it happens at the end of the stop bit. Writing 1 to status bit 1 clears it.
- R9: A received frame is stored in register 0 and sets `rx_irq` (status bit 0). Reading register 0 clears it. The ninth bit received appears in status bit 2.
- R10: Each bit is decided by a two-of-three vote of the middle samples, so a pulse shorter than one tick does not change the data.
- R11: A stop bit sampled 0 sets status bit 3 (framing error). The byte is still stored. Writing 1 to bit 3 clears the flag.
- R12: A frame that is 0 from the start bit through the stop bit sets status bits 4 and 3, and stores no data.
- R13: With nine and control bit 3 (match) both set, a frame is accepted only if its ninth bit is 1 and its byte equals register 4 or 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reading register 0 clears the receive flag) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tim_ovf | input | 1 | External timer overflow pulse |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| tx_irq | output | 1 | Transmitter ready flag |
| rx_irq | output | 1 | Receive data flag |

## Verification
Bit time is measured from the length of the start bit of a 0x01 frame, once for each source. The divider case uses both a value in the low byte only and a value in the high byte only, so a swapped byte order shows up. The transmit tests pair a ninth-bit change made right after a data write with a back-to-back pair in holding mode, which separates latching at write time from sampling at load time. They also include an early second write with holding off. The receive patterns are a clean byte, a glitched zero byte, a bad stop bit, an all-low frame, and four address frames (own, foreign, broadcast, ninth bit clear). Together these separate voting, framing and filter faults.

// File: rtl/usel_pkg.sv
`timescale 1ns/1ps
package usel_pkg;
   typedef enum logic [1:0] {
      SRC_FIX  = 2'd0,
      SRC_TMR  = 2'd1,
      SRC_DIV  = 2'd2,
      SRC_DIVB = 2'd3
   } src_e;

   typedef struct packed {
      logic tx_b8;
      logic dbuf;
      logic match;
      logic nine;
      src_e src;
   } ctrl_t;

   localparam logic [2:0] RA_DATA = 3'd0;
   localparam logic [2:0] RA_CTRL = 3'd1;
   localparam logic [2:0] RA_DIVL = 3'd2;
   localparam logic [2:0] RA_DIVH = 3'd3;
   localparam logic [2:0] RA_OWN  = 3'd4;
   localparam logic [2:0] RA_STAT = 3'd5;
   localparam logic [7:0] BCAST   = 8'hFF;
endpackage

// File: rtl/usel_baud.sv
`timescale 1ns/1ps
module usel_baud
   import usel_pkg::*;
#(
   parameter int FIX_DIV = 4,
   parameter int DIV_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  src_e             src,
   input  logic [DIV_W-1:0] div,
   input  logic             tim_ovf,
   output logic             tick
);
   localparam logic [DIV_W-1:0] FIX_LIM = DIV_W'(FIX_DIV - 1);

   generate
      if (FIX_DIV < 2) begin : g_bad_fix
         $error("FIX_DIV must be at least 2");
      end
      if (FIX_DIV > (1 << DIV_W)) begin : g_bad_w
         $error("FIX_DIV does not fit the counter");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;
   logic             hit;

   always_comb begin
      unique case (src)
         SRC_FIX: hit = (cnt >= FIX_LIM);
         SRC_TMR: hit = tim_ovf;
         default: hit = (cnt >= div);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (hit || src == SRC_TMR) cnt <= '0;
      else                            cnt <= cnt + 1'b1;
   end

   assign tick = hit;

   a_r3_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (src == SRC_DIV || src == SRC_DIVB) && div != '0) |=> (!tick || src == SRC_TMR));
   a_r2_fix_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && src == SRC_FIX) |=> (!tick || src != SRC_FIX));
endmodule

// File: rtl/usel_tx.sv
`timescale 1ns/1ps
module usel_tx #(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       nine,
   input  logic       dbuf,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       wb8,
   output logic       txd,
   output logic       free,
   output logic       occupied
);
   localparam int TW = $clog2(OVS);
   localparam logic [TW-1:0] TLAST = TW'(OVS - 1);

   logic        hold_v;
   logic [8:0]  hold_d;
   logic [10:0] sh;
   logic [TW-1:0] tc;
   logic [3:0]  nleft;
   logic        busy;
   logic        accept, last, ld;
   logic [10:0] frame;

   assign accept = wr && !hold_v && (dbuf || !busy);
   assign last   = busy && tick && (tc == TLAST) && (nleft == 4'd1);
   assign ld     = tick && hold_v && (!busy || last);
   assign frame  = nine ? {1'b1, hold_d[8], hold_d[7:0], 1'b0}
                        : {2'b11, hold_d[7:0], 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_d <= '0;
         sh     <= '1;
         tc     <= '0;
         nleft  <= '0;
         busy   <= 1'b0;
      end else begin
         if (accept) begin
            hold_v <= 1'b1;
            hold_d <= {wb8, wdata};
         end
         if (ld) begin
            hold_v <= 1'b0;
            sh     <= frame;
            tc     <= '0;
            nleft  <= nine ? 4'd11 : 4'd10;
            busy   <= 1'b1;
         end else if (busy && tick) begin
            if (tc == TLAST) begin
               tc    <= '0;
               sh    <= {1'b1, sh[10:1]};
               nleft <= nleft - 4'd1;
               if (nleft == 4'd1) busy <= 1'b0;
            end else begin
               tc <= tc + 1'b1;
            end
         end
      end
   end

   assign txd      = busy ? sh[0] : 1'b1;
   assign free     = dbuf ? ld : last;
   assign occupied = busy || hold_v;

   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_v && !ld) |=> (hold_v && $stable(hold_d)));
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (txd == 1'b0));
   a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dbuf && !ld) |=> !$rose(hold_v));
endmodule

// File: rtl/usel_rx.sv
`timescale 1ns/1ps
module usel_rx #(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   input  logic       nine,
   output logic       done,
   output logic [7:0] data,
   output logic       b8,
   output logic       stop_ok,
   output logic       brk
);
   localparam int TW = $clog2(OVS);
   localparam logic [TW-1:0] TLAST = TW'(OVS - 1);
   localparam logic [TW-1:0] MIDL  = TW'(OVS / 2 - 1);
   localparam logic [TW-1:0] MIDH  = TW'(OVS / 2 + 1);

   logic s1, s2, s3;
   logic active;
   logic [TW-1:0] tc;
   logic [3:0] bidx;
   logic [1:0] ones;
   logic [1:0] votes;
   logic       vote;
   logic [8:0] shreg;
   logic       anyone;
   logic [3:0] last_idx;

   assign votes    = ones + {1'b0, s2};
   assign vote     = (votes >= 2'd2);
   assign last_idx = nine ? 4'd10 : 4'd9;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      end else begin
         s1 <= rxd; s2 <= s1; s3 <= s2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         tc      <= '0;
         bidx    <= '0;
         ones    <= '0;
         shreg   <= '0;
         anyone  <= 1'b0;
         done    <= 1'b0;
         data    <= '0;
         b8      <= 1'b0;
         stop_ok <= 1'b1;
         brk     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (s3 && !s2) begin
               active <= 1'b1;
               tc     <= '0;
               bidx   <= '0;
               ones   <= '0;
               anyone <= 1'b0;
            end
         end else if (tick) begin
            if (tc == TLAST) begin
               tc   <= '0;
               bidx <= bidx + 4'd1;
               ones <= '0;
            end else begin
               tc <= tc + 1'b1;
            end
            if (tc >= MIDL && tc < MIDH) ones <= ones + {1'b0, s2};
            if (tc == MIDH) begin
               if (bidx == 4'd0) begin
                  if (vote) active <= 1'b0;
               end else if (bidx == last_idx) begin
                  done    <= 1'b1;
                  stop_ok <= vote;
                  brk     <= !anyone && !vote;
                  data    <= nine ? shreg[7:0] : shreg[8:1];
                  b8      <= nine ? shreg[8] : 1'b0;
                  active  <= 1'b0;
               end else begin
                  shreg  <= {vote, shreg[8:1]};
                  anyone <= anyone | vote;
               end
            end
         end
      end
   end

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r12_brk_bad_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (done && brk) |-> !stop_ok);
endmodule

// File: rtl/usel_match.sv
`timescale 1ns/1ps
module usel_match
   import usel_pkg::*;
(
   input  logic       filt_on,
   input  logic       b8,
   input  logic [7:0] data,
   input  logic [7:0] own,
   output logic       pass
);
   always_comb begin
      if (!filt_on) pass = 1'b1;
      else          pass = b8 && (data == own || data == BCAST);
   end
endmodule

// File: rtl/usel_uart.sv
`timescale 1ns/1ps
module usel_uart
   import usel_pkg::*;
#(
   parameter int FIX_DIV = 4,
   parameter int OVS     = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [2:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       tim_ovf,
   input  logic       rxd,
   output logic       txd,
   output logic       tx_irq,
   output logic       rx_irq
);
   localparam int DIV_W = 16;

   generate
      if (OVS < 8 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 8");
      end
   endgenerate

   ctrl_t      ctrl;
   logic [DIV_W-1:0] div;
   logic [7:0] own;
   logic [7:0] rx_data;
   logic       rx_b8q, rxf, txf, ferr, brkf;
   logic       tick, tx_free, tx_occ;
   logic       r_done, r_b8, r_stop, r_brk, pass, acc;
   logic [7:0] r_data;
   logic       wr_data, wr_stat;

   assign wr_data = wr_en && addr == RA_DATA;
   assign wr_stat = wr_en && addr == RA_STAT;

   usel_baud #(.FIX_DIV(FIX_DIV), .DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .src(ctrl.src), .div(div),
      .tim_ovf(tim_ovf), .tick(tick));

   usel_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .nine(ctrl.nine), .dbuf(ctrl.dbuf),
      .wr(wr_data), .wdata(wdata), .wb8(ctrl.tx_b8), .txd(txd),
      .free(tx_free), .occupied(tx_occ));

   usel_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine(ctrl.nine),
      .done(r_done), .data(r_data), .b8(r_b8), .stop_ok(r_stop), .brk(r_brk));

   usel_match u_match (
      .filt_on(ctrl.nine && ctrl.match), .b8(r_b8), .data(r_data),
      .own(own), .pass(pass));

   assign acc = r_done && !r_brk && pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         div     <= '0;
         own     <= '0;
         rx_data <= '0;
         rx_b8q  <= 1'b0;
         rxf     <= 1'b0;
         txf     <= 1'b0;
         ferr    <= 1'b0;
         brkf    <= 1'b0;
      end else begin
         if (wr_en) begin
            unique case (addr)
               RA_CTRL: ctrl <= ctrl_t'(wdata[5:0]);
               RA_DIVL: div[7:0]  <= wdata;
               RA_DIVH: div[15:8] <= wdata;
               RA_OWN:  own <= wdata;
               default: ;
            endcase
         end
         if (acc) begin
            rxf     <= 1'b1;
            rx_data <= r_data;
            rx_b8q  <= r_b8;
         end else if (rd_en && addr == RA_DATA) begin
            rxf <= 1'b0;
         end
         if (tx_free)                   txf  <= 1'b1;
         else if (wr_stat && wdata[1])  txf  <= 1'b0;
         if (r_done && !r_stop)         ferr <= 1'b1;
         else if (wr_stat && wdata[3])  ferr <= 1'b0;
         if (r_done && r_brk)           brkf <= 1'b1;
         else if (wr_stat && wdata[4])  brkf <= 1'b0;
      end
   end

   always_comb begin
      unique case (addr)
         RA_DATA: rdata = rx_data;
         RA_CTRL: rdata = {2'b00, ctrl};
         RA_DIVL: rdata = div[7:0];
         RA_DIVH: rdata = div[15:8];
         RA_OWN:  rdata = own;
         RA_STAT: rdata = {2'b00, tx_occ, brkf, ferr, rx_b8q, txf, rxf};
         default: rdata = 8'h00;
      endcase
   end

   assign tx_irq = txf;
   assign rx_irq = rxf;

   a_r12_brk_with_ferr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brkf) |-> ferr);
   a_r13_filter_b8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rxf) && $past(ctrl.nine && ctrl.match)) |-> rx_b8q);
   a_r12_brk_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (r_done && r_brk && !rxf) |=> !rxf);
endmodule

// File: tb/tb_usel_uart.sv
`timescale 1ns/1ps
module tb_usel_uart;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       tim_ovf = 1'b0;
   logic       rxd = 1'b1;
   logic       txd, tx_irq, rx_irq;
   int         tests = 0, fails = 0, cyc = 0;
   bit         tmr_on = 1'b0;
   int         pc = 0;
   localparam int BC = 64;

   always #2.5 clk = ~clk;

   usel_uart #(.FIX_DIV(4), .OVS(16)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tim_ovf(tim_ovf), .rxd(rxd), .txd(txd),
      .tx_irq(tx_irq), .rx_irq(rx_irq));

   always @(negedge clk) begin
      if (tmr_on) begin
         tim_ovf = (pc == 5);
         pc = (pc == 5) ? 0 : pc + 1;
      end else begin
         tim_ovf = 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 190000) begin
         tests++; fails++;
         $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      do rd(3'd5, s); while (s[5]);
      repeat (4) @(negedge clk);
   endtask

   task automatic meas_low(output int n);
      while (txd !== 1'b0) @(negedge clk);
      n = 0;
      while (txd === 1'b0) begin n++; @(negedge clk); end
   endtask

   task automatic cap(input int bc, input bit nine, output logic [8:0] d, output logic stp);
      d = '0;
      while (txd !== 1'b0) @(negedge clk);
      repeat (bc / 2) @(negedge clk);
      for (int i = 0; i < (nine ? 9 : 8); i++) begin
         repeat (bc) @(negedge clk);
         d[i] = txd;
      end
      repeat (bc) @(negedge clk);
      stp = txd;
   endtask

   task automatic send(input logic [8:0] d, input bit nine, input logic stp, input int gbit);
      logic [10:0] bits;
      int n;
      n = nine ? 11 : 10;
      bits = '0;
      for (int i = 0; i < 8; i++) bits[i+1] = d[i];
      if (nine) bits[9] = d[8];
      bits[n-1] = stp;
      for (int b = 0; b < n; b++) begin
         for (int c = 0; c < BC; c++) begin
            @(negedge clk);
            if (b == gbit && c >= BC/2 + 4 && c < BC/2 + 7) rxd = ~bits[b];
            else rxd = bits[b];
         end
      end
      @(negedge clk); rxd = 1'b1;
      repeat (2 * BC) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] s;
      chk("R1 txd idle", txd, 1'b1);
      chk("R1 tx_irq", tx_irq, 1'b0);
      chk("R1 rx_irq", rx_irq, 1'b0);
      rd(3'd5, s);
      chk("R1 status", s, 8'h00);
   endtask

   task automatic t_fixed();
      int n; logic [8:0] d; logic stp;
      wr(3'd1, 8'h00);
      fork meas_low(n); wr(3'd0, 8'h01); join
      chk("R2 bit time fixed", n, 64);
      wait_idle();
      fork cap(BC, 1'b0, d, stp); wr(3'd0, 8'hA5); join
      chk("R2 data LSB first", d[7:0], 8'hA5);
      chk("R2 stop bit", stp, 1'b1);
      wait_idle();
      chk("R8 tx_irq after stop", tx_irq, 1'b1);
      wr(3'd5, 8'h02);
      chk("R8 tx_irq cleared", tx_irq, 1'b0);
   endtask

   task automatic t_div();
      int n;
      wr(3'd2, 8'd9); wr(3'd3, 8'd0); wr(3'd1, 8'h02);
      fork meas_low(n); wr(3'd0, 8'h01); join
      chk("R3 bit time div low byte", n, 160);
      wait_idle();
      wr(3'd2, 8'd0); wr(3'd3, 8'd1);
      fork meas_low(n); wr(3'd0, 8'h01); join
      chk("R3 bit time div high byte", n, 4112);
      wait_idle();
   endtask

   task automatic t_tmr();
      int n, lows;
      wr(3'd1, 8'h01);
      wr(3'd0, 8'h01);
      lows = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (txd === 1'b0) lows++; end
      chk("R4 no pulses no output", lows, 0);
      tmr_on = 1'b1;
      meas_low(n);
      chk("R4 bit time timer", n, 96);
      wait_idle();
      tmr_on = 1'b0;
      wr(3'd1, 8'h00);
   endtask

   task automatic t_nine();
      logic [8:0] d; logic stp;
      wr(3'd1, 8'h24);
      fork
         cap(BC, 1'b1, d, stp);
         begin wr(3'd0, 8'h5A); wr(3'd1, 8'h04); end
      join
      chk("R5 ninth bit latched at write", d, 9'h15A);
      chk("R5 stop", stp, 1'b1);
      wait_idle();
   endtask

   task automatic t_dbuf();
      logic [8:0] d1, d2; logic s1, s2;
      wr(3'd5, 8'h02);
      wr(3'd1, 8'h34);
      fork
         begin cap(BC, 1'b1, d1, s1); cap(BC, 1'b1, d2, s2); end
         begin
            wr(3'd0, 8'h3C); wr(3'd1, 8'h14);
            repeat (8) @(negedge clk);
            chk("R8 tx_irq on load with holding", tx_irq, 1'b1);
            wr(3'd0, 8'hC3);
         end
      join
      chk("R6 first frame", d1, 9'h13C);
      chk("R6 second frame", d2, 9'h0C3);
      wait_idle();
   endtask

   task automatic t_drop();
      logic [8:0] d; logic stp; int lows;
      wr(3'd1, 8'h00);
      fork
         cap(BC, 1'b0, d, stp);
         begin wr(3'd0, 8'h11); repeat (20) @(negedge clk); wr(3'd0, 8'h22); end
      join
      chk("R7 first byte sent", d[7:0], 8'h11);
      lows = 0;
      for (int i = 0; i < 3 * BC; i++) begin @(negedge clk); if (txd === 1'b0) lows++; end
      chk("R7 write while busy ignored", lows, 0);
   endtask

   task automatic t_rx();
      logic [7:0] v, s;
      wr(3'd1, 8'h00);
      send(9'h05A, 1'b0, 1'b1, -1);
      chk("R9 rx_irq set", rx_irq, 1'b1);
      rd(3'd0, v);
      chk("R9 data", v, 8'h5A);
      chk("R9 read clears", rx_irq, 1'b0);
      send(9'h000, 1'b0, 1'b1, 4);
      rd(3'd0, v);
      chk("R10 glitch voted out", v, 8'h00);
      send(9'h033, 1'b0, 1'b0, -1);
      rd(3'd5, s);
      chk("R11 framing error flag", s[4:3], 2'b01);
      rd(3'd0, v);
      chk("R11 data kept", v, 8'h33);
      wr(3'd5, 8'h08);
      rd(3'd5, s);
      chk("R11 flag cleared", s[3], 1'b0);
      send(9'h000, 1'b0, 1'b0, -1);
      rd(3'd5, s);
      chk("R12 break and framing flags", s[4:3], 2'b11);
      chk("R12 no data stored", s[0], 1'b0);
      wr(3'd5, 8'h18);
   endtask

   task automatic t_match();
      logic [7:0] v, s;
      wr(3'd4, 8'h42); wr(3'd1, 8'h0C);
      send(9'h142, 1'b1, 1'b1, -1);
      rd(3'd5, s);
      chk("R13 own address accepted", s[0], 1'b1);
      chk("R9 ninth bit status", s[2], 1'b1);
      rd(3'd0, v);
      chk("R13 own address value", v, 8'h42);
      send(9'h143, 1'b1, 1'b1, -1);
      chk("R13 foreign address dropped", rx_irq, 1'b0);
      send(9'h1FF, 1'b1, 1'b1, -1);
      rd(3'd0, v);
      chk("R13 broadcast accepted", v, 8'hFF);
      chk("R13 broadcast cleared by read", rx_irq, 1'b0);
      send(9'h042, 1'b1, 1'b1, -1);
      chk("R13 ninth bit clear dropped", rx_irq, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_fixed();
      t_div();
      t_tmr();
      t_nine();
      t_dbuf();
      t_drop();
      t_rx();
      t_match();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule